// File: doc/BRIEF.md
# Prioritised Interrupt Aggregator

This block gathers a set of interrupt source lines and folds them into a single request line for a processor. Each source line carries its own fixed trigger setting, chosen when the block is built: it is either edge or level sensitive, and either active high or active low. A source line that fires latches a bit in a pending register. The processor reaches the pending register, a per-line enable mask and a master gate through a single-cycle register port. That port has an address, a write strobe, write data and combinational read data.

The request output is raised whenever some pending line is also enabled and the master gate is open. Alongside it the block reports the index of the winning line. The lowest-numbered line always wins. An interrupt service routine reads the pending register, handles the lines it finds, and then writes ones to the acknowledge location to retire them.

Top module: `irq_hub`

## Requirements
- R1: Reset (rstN low) clears the pending, enable and master registers, so every readable location returns 0 and irq is 0.
- R2: Offset 0x00 reads back the pending bits in bits [NUM_SRC-1:0]; a write there sets every pending bit whose data bit is 1 and leaves the others unchanged.
- R3: Offset 0x08 is the enable mask, readable and writable in bits [NUM_SRC-1:0]; a line with its enable bit at 0 never contributes to irq or irqId.
- R4: Writing 1 to a bit at offset 0x0C clears that pending bit on the next clock edge; reads of 0x0C return 0.
- R5: Offset 0x1C bit 0 is the master gate; while it is 0, irq stays 0 whatever is pending.
- R6: irq equals the OR over all lines of (pending AND enable), gated by the master bit.
- R7: irqId is the index of the lowest set bit of (pending AND enable), independent of the master bit, and 0 when that vector is empty.
- R8: An edge-sensitive line sets its pending bit at the second clock edge after its active transition; holding it active afterwards does not set the bit again once it has been acknowledged.
- R9: A level-sensitive line sets its pending bit on every clock edge while it is active (with the same two-edge delay), so an acknowledge cannot clear it while the line stays active.
- R10: On an active-low line, a low level (or a falling edge, if edge sensitive) is the active condition; a rising edge on such a line sets nothing.
- R11: Offsets other than 0x00, 0x08, 0x0C and 0x1C read 0, and writes to them change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| srcIn | input | NUM_SRC | Raw interrupt source lines |
| busAddr | input | ADDR_W | Byte offset of the register access |
| busWe | input | 1 | Write strobe for the current cycle |
| busWdata | input | DATA_W | Write data |
| busRdata | output | DATA_W | Read data for busAddr, combinational |
| irq | output | 1 | Request line to the processor |
| irqId | output | ID_W | Index of the highest-priority pending enabled line |

## Verification
The bench builds the block with four lines. Line 0 is a falling-edge input, line 1 is active-low level, line 2 is rising-edge and line 3 is active-high level. This gives one line of each sensitivity and polarity combination. With only four lines, the bench can sweep every pending pattern against every enable mask under both master settings. It compares irq, irqId and the read-back values against arithmetic on the pattern. Directed sequences then cover the two-edge capture delay, the re-setting of level lines after an acknowledge, and inverted polarity.

// File: rtl/irq_hub_pkg.sv
package irq_hub_pkg;

  localparam int unsigned OFF_PEND   = 32'h00;
  localparam int unsigned OFF_ENAB   = 32'h08;
  localparam int unsigned OFF_ACK    = 32'h0C;
  localparam int unsigned OFF_MASTER = 32'h1C;

  typedef enum logic [1:0] {
    RD_NONE,
    RD_PEND,
    RD_ENAB,
    RD_MASTER
  } rdSel_e;

  typedef struct packed {
    logic   setPend;
    logic   setEnab;
    logic   clrAck;
    logic   setMaster;
    rdSel_e rdSel;
  } strobe_t;

endpackage

// File: rtl/irq_hub_ctrl.sv
module irq_hub_ctrl
  import irq_hub_pkg::*;
#(
  parameter int ADDR_W = 5
) (
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWe,
  output strobe_t           strobe
);

  localparam logic [ADDR_W-1:0] A_PEND   = ADDR_W'(OFF_PEND);
  localparam logic [ADDR_W-1:0] A_ENAB   = ADDR_W'(OFF_ENAB);
  localparam logic [ADDR_W-1:0] A_ACK    = ADDR_W'(OFF_ACK);
  localparam logic [ADDR_W-1:0] A_MASTER = ADDR_W'(OFF_MASTER);

  always_comb begin
    strobe = '{setPend: 1'b0, setEnab: 1'b0, clrAck: 1'b0,
               setMaster: 1'b0, rdSel: RD_NONE};
    if (busAddr == A_PEND) begin
      strobe.setPend = busWe;
      strobe.rdSel   = RD_PEND;
    end else if (busAddr == A_ENAB) begin
      strobe.setEnab = busWe;
      strobe.rdSel   = RD_ENAB;
    end else if (busAddr == A_ACK) begin
      strobe.clrAck  = busWe;
    end else if (busAddr == A_MASTER) begin
      strobe.setMaster = busWe;
      strobe.rdSel     = RD_MASTER;
    end
  end

endmodule

// File: rtl/irq_hub_datapath.sv
module irq_hub_datapath
  import irq_hub_pkg::*;
#(
  parameter int                   NUM_SRC   = 8,
  parameter int                   DATA_W    = 32,
  parameter logic [NUM_SRC-1:0]   EDGE_MASK = '0,
  parameter logic [NUM_SRC-1:0]   LOW_MASK  = '0,
  localparam int                  ID_W      = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [NUM_SRC-1:0] srcIn,
  input  strobe_t            strobe,
  input  logic [DATA_W-1:0]  wrData,
  output logic [DATA_W-1:0]  rdData,
  output logic               irq,
  output logic [ID_W-1:0]    irqId
);

  logic [NUM_SRC-1:0] actQ, actPrev, pendQ, enabQ;
  logic               masterQ;
  logic [NUM_SRC-1:0] hits, swSet, ackClr, pendNext, live;

  // capture the polarity-corrected lines and their previous value
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      actQ    <= '0;
      actPrev <= '0;
    end else begin
      actQ    <= srcIn ^ LOW_MASK;
      actPrev <= actQ;
    end
  end

  for (genvar i = 0; i < NUM_SRC; i++) begin : g_sense
    if (EDGE_MASK[i]) begin : g_edge
      assign hits[i] = actQ[i] & ~actPrev[i];
    end else begin : g_level
      assign hits[i] = actQ[i];
    end
  end

  assign swSet    = strobe.setPend ? wrData[NUM_SRC-1:0] : '0;
  assign ackClr   = strobe.clrAck  ? wrData[NUM_SRC-1:0] : '0;
  assign pendNext = (pendQ & ~ackClr) | swSet | hits;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pendQ   <= '0;
      enabQ   <= '0;
      masterQ <= 1'b0;
    end else begin
      pendQ <= pendNext;
      if (strobe.setEnab)   enabQ   <= wrData[NUM_SRC-1:0];
      if (strobe.setMaster) masterQ <= wrData[0];
    end
  end

  assign live = pendQ & enabQ;
  assign irq  = masterQ & (|live);

  // scan downward so the lowest set bit is the last to win
  always_comb begin
    irqId = '0;
    for (int i = NUM_SRC - 1; i >= 0; i--) begin
      if (live[i]) irqId = ID_W'(i);
    end
  end

  always_comb begin
    rdData = '0;
    case (strobe.rdSel)
      RD_PEND:   rdData[NUM_SRC-1:0] = pendQ;
      RD_ENAB:   rdData[NUM_SRC-1:0] = enabQ;
      RD_MASTER: rdData[0]           = masterQ;
      default:   rdData              = '0;
    endcase
  end

endmodule

// File: rtl/irq_hub.sv
module irq_hub
  import irq_hub_pkg::*;
#(
  parameter int                 NUM_SRC   = 8,
  parameter int                 ADDR_W    = 5,
  parameter int                 DATA_W    = 32,
  parameter logic [NUM_SRC-1:0] EDGE_MASK = '0,
  parameter logic [NUM_SRC-1:0] LOW_MASK  = '0,
  localparam int                ID_W      = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [NUM_SRC-1:0] srcIn,
  input  logic [ADDR_W-1:0]  busAddr,
  input  logic               busWe,
  input  logic [DATA_W-1:0]  busWdata,
  output logic [DATA_W-1:0]  busRdata,
  output logic               irq,
  output logic [ID_W-1:0]    irqId
);

  strobe_t strobe;

  irq_hub_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
    .busAddr (busAddr),
    .busWe   (busWe),
    .strobe  (strobe)
  );

  irq_hub_datapath #(
    .NUM_SRC   (NUM_SRC),
    .DATA_W    (DATA_W),
    .EDGE_MASK (EDGE_MASK),
    .LOW_MASK  (LOW_MASK)
  ) u_dp (
    .clk    (clk),
    .rstN   (rstN),
    .srcIn  (srcIn),
    .strobe (strobe),
    .wrData (busWdata),
    .rdData (busRdata),
    .irq    (irq),
    .irqId  (irqId)
  );

endmodule

// File: rtl/irq_hub_chk.sv
module irq_hub_chk
  import irq_hub_pkg::*;
#(
  parameter int  NUM_SRC = 8,
  parameter int  ADDR_W  = 5,
  parameter int  DATA_W  = 32,
  localparam int ID_W    = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1
) (
  input logic               clk,
  input logic               rstN,
  input logic [ADDR_W-1:0]  busAddr,
  input logic               busWe,
  input logic [DATA_W-1:0]  busWdata,
  input logic [DATA_W-1:0]  busRdata,
  input logic               irq,
  input logic [ID_W-1:0]    irqId
);

  localparam logic [ADDR_W-1:0] A_PEND   = ADDR_W'(OFF_PEND);
  localparam logic [ADDR_W-1:0] A_ENAB   = ADDR_W'(OFF_ENAB);
  localparam logic [ADDR_W-1:0] A_ACK    = ADDR_W'(OFF_ACK);
  localparam logic [ADDR_W-1:0] A_MASTER = ADDR_W'(OFF_MASTER);
  localparam logic [ADDR_W-1:0] A_HOLE   = ADDR_W'(4);

  // R5
  master_off_chk: assert property (@(posedge clk) disable iff (!rstN)
    (busWe && busAddr == A_MASTER && !busWdata[0]) |=> !irq);

  // R3
  enable_off_chk: assert property (@(posedge clk) disable iff (!rstN)
    (busWe && busAddr == A_ENAB && busWdata[NUM_SRC-1:0] == '0) |=> !irq);

  // R4
  ack_read_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!busWe && busAddr == A_ACK) |-> busRdata == '0);

  // R2
  pend_set_chk: assert property (@(posedge clk) disable iff (!rstN)
    (busWe && busAddr == A_PEND) ##1 (busAddr == A_PEND) |->
      ((busRdata[NUM_SRC-1:0] & $past(busWdata[NUM_SRC-1:0])) ==
       $past(busWdata[NUM_SRC-1:0])));

  // R11
  hole_read_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    (busAddr == A_HOLE) |-> busRdata == '0);

endmodule

bind irq_hub irq_hub_chk #(
  .NUM_SRC (NUM_SRC),
  .ADDR_W  (ADDR_W),
  .DATA_W  (DATA_W)
) u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .busAddr  (busAddr),
  .busWe    (busWe),
  .busWdata (busWdata),
  .busRdata (busRdata),
  .irq      (irq),
  .irqId    (irqId)
);

// File: tb/test_irq_hub.sv
`timescale 1ns/1ps
module test_irq_hub;

  localparam int             N    = 4;
  localparam int             AW   = 5;
  localparam int             DW   = 32;
  localparam logic [N-1:0]   EDGE = 4'b0101;
  localparam logic [N-1:0]   LOW  = 4'b0011;
  localparam logic [N-1:0]   IDLE = 4'b0011;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic [N-1:0]  srcIn = IDLE;
  logic [AW-1:0] busAddr = '0;
  logic          busWe = 1'b0;
  logic [DW-1:0] busWdata = '0;
  logic [DW-1:0] busRdata;
  logic          irq;
  logic [1:0]    irqId;

  int nChecks = 0;
  int nFails  = 0;
  bit done    = 1'b0;

  always #2 clk = ~clk;

  irq_hub #(.NUM_SRC(N), .ADDR_W(AW), .DATA_W(DW),
            .EDGE_MASK(EDGE), .LOW_MASK(LOW)) i_irq_hub (
    .clk(clk), .rstN(rstN), .srcIn(srcIn), .busAddr(busAddr), .busWe(busWe),
    .busWdata(busWdata), .busRdata(busRdata), .irq(irq), .irqId(irqId)
  );

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic tick(int n);
    for (int k = 0; k < n; k++) @(negedge clk);
  endtask

  task automatic wr(logic [AW-1:0] a, logic [DW-1:0] d);
    @(negedge clk);
    busAddr = a; busWdata = d; busWe = 1'b1;
    @(negedge clk);
    busWe = 1'b0;
  endtask

  task automatic rd(logic [AW-1:0] a, output logic [DW-1:0] d);
    busAddr = a; busWe = 1'b0;
    #1 d = busRdata;
  endtask

  function automatic logic [1:0] lowest(logic [N-1:0] v);
    for (int i = 0; i < N; i++) if (v[i]) return 2'(i);
    return 2'd0;
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      nChecks++; nFails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    logic [DW-1:0] r;
    tick(3);
    // R1 reset state
    rd(5'h00, r); check("R1 pend", r, 0);
    rd(5'h08, r); check("R1 enab", r, 0);
    rd(5'h1C, r); check("R1 master", r, 0);
    check("R1 irq", 32'(irq), 0);
    rstN = 1'b1;
    tick(2);

    // sweep pending x enable x master
    for (int m = 0; m < 2; m++) begin
      for (int e = 0; e < 16; e++) begin
        for (int p = 0; p < 16; p++) begin
          wr(5'h0C, 32'hF);
          wr(5'h00, 32'(p));
          wr(5'h08, 32'(e));
          wr(5'h1C, 32'(m));
          rd(5'h00, r); check("R2 pend readback", r, 32'(p));
          rd(5'h08, r); check("R3 enab readback", r, 32'(e));
          check("R5 R6 irq", 32'(irq), 32'((m == 1) && ((p & e) != 0)));
          check("R7 irqId", 32'(irqId), 32'(lowest(4'(p & e))));
        end
        rd(5'h0C, r); check("R4 ack reads zero", r, 0);
      end
    end

    // R11 unmapped offsets
    wr(5'h0C, 32'hF);
    wr(5'h08, 32'h0);
    wr(5'h04, 32'hFFFF_FFFF);
    wr(5'h10, 32'hFFFF_FFFF);
    wr(5'h14, 32'hFFFF_FFFF);
    wr(5'h18, 32'hFFFF_FFFF);
    rd(5'h04, r); check("R11 hole read", r, 0);
    rd(5'h18, r); check("R11 hole read", r, 0);
    rd(5'h00, r); check("R11 pend untouched", r, 0);
    rd(5'h08, r); check("R11 enab untouched", r, 0);
    rd(5'h1C, r); check("R11 master untouched", r, 1);

    // R4 acknowledge clears a set bit
    wr(5'h00, 32'hA);
    wr(5'h0C, 32'h2);
    rd(5'h00, r); check("R4 ack clears", r, 32'h8);
    wr(5'h0C, 32'hF);
    wr(5'h08, 32'hF);

    // R8 rising edge on line 2
    @(negedge clk); srcIn = IDLE | 4'b0100;
    tick(1);
    rd(5'h00, r); check("R8 not yet after one edge", r, 0);
    tick(1);
    rd(5'h00, r); check("R8 edge sets", r, 32'h4);
    check("R7 irqId line2", 32'(irqId), 2);
    wr(5'h0C, 32'h4);
    tick(3);
    rd(5'h00, r); check("R8 held edge not re-set", r, 0);
    @(negedge clk); srcIn = IDLE;
    tick(3);

    // R9 level line 3 active high
    @(negedge clk); srcIn = IDLE | 4'b1000;
    tick(2);
    rd(5'h00, r); check("R9 level sets", r, 32'h8);
    wr(5'h0C, 32'h8);
    rd(5'h00, r); check("R9 level survives ack", r, 32'h8);
    @(negedge clk); srcIn = IDLE;
    tick(2);
    wr(5'h0C, 32'h8);
    rd(5'h00, r); check("R9 clears once inactive", r, 0);

    // R10 level line 1 active low
    @(negedge clk); srcIn = IDLE & ~4'b0010;
    tick(2);
    rd(5'h00, r); check("R10 low level sets", r, 32'h2);
    check("R7 irqId line1", 32'(irqId), 1);
    @(negedge clk); srcIn = IDLE;
    tick(2);
    wr(5'h0C, 32'hF);

    // R10 falling edge on line 0
    @(negedge clk); srcIn = IDLE & ~4'b0001;
    tick(2);
    rd(5'h00, r); check("R10 falling edge sets", r, 32'h1);
    check("R7 irqId line0", 32'(irqId), 0);
    wr(5'h0C, 32'h1);
    tick(2);
    rd(5'h00, r); check("R8 held low not re-set", r, 0);
    @(negedge clk); srcIn = IDLE;
    tick(3);
    rd(5'h00, r); check("R10 rising on low line ignored", r, 0);

    // R1 reset mid-run
    wr(5'h00, 32'hF);
    @(negedge clk); rstN = 1'b0;
    #1;
    rd(5'h00, r); check("R1 pend after reset", r, 0);
    rd(5'h08, r); check("R1 enab after reset", r, 0);
    rd(5'h1C, r); check("R1 master after reset", r, 0);
    check("R1 irq after reset", 32'(irq), 0);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end

endmodule